// File: doc/BRIEF.md
# Integer Instruction Execute Unit

This block is the combinational execute step of a 32-bit load/store processor core. Each evaluation takes one instruction word and the two values read from the register file for it. It returns the computed result, the index of the register to write, a register-write enable, and read and write strobes for data memory. Register-format operations share a single primary opcode and pick their operation from a function field. Immediate-format operations are picked by the primary opcode alone.

Loads and stores do not reach memory here. For them the result output carries the effective address, and the strobes tell the surrounding core which access to start. Signed-overflow detection and the illegal-instruction flag are both local to the block. Both cancel side effects in the same evaluation, so the core never has to reverse a write.

Top module: `exe_unit`

## Requirements
- R1: The word is split as opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], function [5:0], immediate [15:0]. Opcode 000000 writes register rd. Every other accepted opcode writes register rt.
- R2: Under opcode 000000, function 100000 (add) and 100001 (addu) give rs+rt, and 100010 (sub) and 100011 (subu) give rs-rt, all modulo 2^32.
- R3: Signed overflow sets the overflow output and clears the register-write enable, but only for add, sub and addi (opcode 001000). addu, subu and addiu (opcode 001001) never set it. When overflow is flagged, the result still carries the wrapped value.
- R4: Under opcode 000000, function 100100 gives rs AND rt, 100101 gives OR, 100110 gives XOR and 100111 gives NOR.
- R5: Function 000000 (sll) gives rt shifted left by the shift-amount field. Function 000100 (sllv) gives rt shifted left by bits [4:0] of rs.
- R6: addi and addiu add the sign-extended immediate to rs. andi (001100), ori (001101) and xori (001110) combine rs with the zero-extended immediate.
- R7: lui (001111) returns the immediate in bits [31:16] and zero in bits [15:0].
- R8: lw (100011) returns rs plus the sign-extended immediate, with the memory read strobe and register write set. sw (101011) returns the same address with only the memory write strobe set.
- R9: Any opcode other than those listed, or any function code other than those listed under opcode 000000, sets the illegal output. It also forces the register write and both memory strobes low and the result to zero.
- R10: The two memory strobes are never high together, and the register write is never high together with the memory write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of register rs |
| rt_val | input | 32 | Value of register rt |
| alu_result | output | 32 | Computed value or effective address |
| dest_idx | output | 5 | Register index to write |
| reg_we | output | 1 | Register write enable |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| ovf | output | 1 | Signed overflow on a trapping add or subtract |
| illegal | output | 1 | Unrecognised opcode or function code |

## Verification
The bound checker re-checks several properties on every evaluation. It confirms the choice of destination field for each format, that overflow appears only on the three trapping opcodes and always with the write withheld, and that an illegal word stays quiet. It also checks the result layout of lui, the load address, and the exclusivity of the strobes. The arithmetic values, the modulo wrap, the two shift sources and the difference between sign and zero extension are covered by the bench's reference model instead. That model is fed directed corner words and mixed random traffic, and is compared against the outputs on every clock.

// File: rtl/exe_pkg.sv
package exe_pkg;

   localparam logic [5:0] OPC_REG   = 6'b000000;
   localparam logic [5:0] OPC_ADDI  = 6'b001000;
   localparam logic [5:0] OPC_ADDIU = 6'b001001;
   localparam logic [5:0] OPC_ANDI  = 6'b001100;
   localparam logic [5:0] OPC_ORI   = 6'b001101;
   localparam logic [5:0] OPC_XORI  = 6'b001110;
   localparam logic [5:0] OPC_LUI   = 6'b001111;
   localparam logic [5:0] OPC_LW    = 6'b100011;
   localparam logic [5:0] OPC_SW    = 6'b101011;

   localparam logic [5:0] FUN_SLL   = 6'b000000;
   localparam logic [5:0] FUN_SLLV  = 6'b000100;
   localparam logic [5:0] FUN_ADD   = 6'b100000;
   localparam logic [5:0] FUN_ADDU  = 6'b100001;
   localparam logic [5:0] FUN_SUB   = 6'b100010;
   localparam logic [5:0] FUN_SUBU  = 6'b100011;
   localparam logic [5:0] FUN_AND   = 6'b100100;
   localparam logic [5:0] FUN_OR    = 6'b100101;
   localparam logic [5:0] FUN_XOR   = 6'b100110;
   localparam logic [5:0] FUN_NOR   = 6'b100111;

   typedef enum logic [2:0] {
      XU_ADD, XU_SUB, XU_AND, XU_OR, XU_XOR, XU_NOR, XU_SHL, XU_UPPER
   } xu_op_e;

   typedef struct packed {
      xu_op_e op;
      logic   use_imm;
      logic   zero_ext;
      logic   shift_by_reg;
      logic   trap_ovf;
      logic   dst_is_rd;
      logic   wr_reg;
      logic   rd_mem;
      logic   wr_mem;
      logic   bad;
   } xu_ctrl_t;

endpackage

// File: rtl/exe_decode.sv
module exe_decode
   import exe_pkg::*;
#(
   parameter int OPC_W = 6,
   parameter int FUN_W = 6
) (
   input  logic [OPC_W-1:0] opcode,
   input  logic [FUN_W-1:0] funct,
   output xu_ctrl_t         ctrl
);

   if (OPC_W != 6 || FUN_W != 6) begin : g_bad_code_width
      $error("exe_decode: code map needs 6-bit opcode and function fields");
   end

   xu_ctrl_t c;

   always_comb begin
      c = '0;
      case (opcode)
         OPC_REG: begin
            c.dst_is_rd = 1'b1;
            c.wr_reg    = 1'b1;
            case (funct)
               FUN_ADD:  begin c.op = XU_ADD; c.trap_ovf = 1'b1; end
               FUN_ADDU: c.op = XU_ADD;
               FUN_SUB:  begin c.op = XU_SUB; c.trap_ovf = 1'b1; end
               FUN_SUBU: c.op = XU_SUB;
               FUN_AND:  c.op = XU_AND;
               FUN_OR:   c.op = XU_OR;
               FUN_XOR:  c.op = XU_XOR;
               FUN_NOR:  c.op = XU_NOR;
               FUN_SLL:  c.op = XU_SHL;
               FUN_SLLV: begin c.op = XU_SHL; c.shift_by_reg = 1'b1; end
               default:  c.bad = 1'b1;
            endcase
         end
         OPC_ADDI: begin
            c.op = XU_ADD; c.use_imm = 1'b1; c.wr_reg = 1'b1; c.trap_ovf = 1'b1;
         end
         OPC_ADDIU: begin
            c.op = XU_ADD; c.use_imm = 1'b1; c.wr_reg = 1'b1;
         end
         OPC_ANDI: begin
            c.op = XU_AND; c.use_imm = 1'b1; c.zero_ext = 1'b1; c.wr_reg = 1'b1;
         end
         OPC_ORI: begin
            c.op = XU_OR; c.use_imm = 1'b1; c.zero_ext = 1'b1; c.wr_reg = 1'b1;
         end
         OPC_XORI: begin
            c.op = XU_XOR; c.use_imm = 1'b1; c.zero_ext = 1'b1; c.wr_reg = 1'b1;
         end
         OPC_LUI: begin
            c.op = XU_UPPER; c.use_imm = 1'b1; c.zero_ext = 1'b1; c.wr_reg = 1'b1;
         end
         OPC_LW: begin
            c.op = XU_ADD; c.use_imm = 1'b1; c.wr_reg = 1'b1; c.rd_mem = 1'b1;
         end
         OPC_SW: begin
            c.op = XU_ADD; c.use_imm = 1'b1; c.wr_mem = 1'b1;
         end
         default: c.bad = 1'b1;
      endcase
      if (c.bad) begin
         c.wr_reg   = 1'b0;
         c.rd_mem   = 1'b0;
         c.wr_mem   = 1'b0;
         c.trap_ovf = 1'b0;
      end
   end

   assign ctrl = c;

endmodule

// File: rtl/exe_immext.sv
module exe_immext #(
   parameter int IMM_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic [IMM_W-1:0]  imm,
   input  logic              zero_ext,
   output logic [DATA_W-1:0] ext
);

   localparam int PAD_W = DATA_W - IMM_W;

   if (PAD_W < 1) begin : g_bad_pad
      $error("exe_immext: data width must exceed immediate width");
   end

   logic fill;
   assign fill = zero_ext ? 1'b0 : imm[IMM_W-1];
   assign ext  = {{PAD_W{fill}}, imm};

endmodule

// File: rtl/exe_shifter.sv
module exe_shifter #(
   parameter int DATA_W = 32,
   parameter int SH_W   = 5
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   output logic [DATA_W-1:0] dout
);

   if ((1 << SH_W) != DATA_W) begin : g_bad_shift_w
      $error("exe_shifter: shift count width must span the data width");
   end

   logic [DATA_W-1:0] stage [SH_W+1];

   assign stage[0] = din;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
   end

   assign dout = stage[SH_W];

endmodule

// File: rtl/exe_alu.sv
module exe_alu
   import exe_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SH_W   = 5,
   parameter int IMM_W  = 16
) (
   input  xu_op_e            op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [SH_W-1:0]   shamt,
   output logic [DATA_W-1:0] result,
   output logic              ovf_raw
);

   localparam int MSB = DATA_W - 1;
   localparam logic [SH_W-1:0] UPPER_SH = SH_W'(IMM_W);

   logic [DATA_W-1:0] sum, diff, shl_out;
   logic [SH_W-1:0]   sh_sel;

   assign sum  = opa + opb;
   assign diff = opa - opb;

   assign sh_sel = (op == XU_UPPER) ? UPPER_SH : shamt;

   exe_shifter #(
      .DATA_W (DATA_W),
      .SH_W   (SH_W)
   ) u_shl (
      .din  (opb),
      .amt  (sh_sel),
      .dout (shl_out)
   );

   always_comb begin
      result  = '0;
      ovf_raw = 1'b0;
      case (op)
         XU_ADD: begin
            result  = sum;
            ovf_raw = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
         end
         XU_SUB: begin
            result  = diff;
            ovf_raw = (opa[MSB] != opb[MSB]) && (diff[MSB] != opa[MSB]);
         end
         XU_AND:   result = opa & opb;
         XU_OR:    result = opa | opb;
         XU_XOR:   result = opa ^ opb;
         XU_NOR:   result = ~(opa | opb);
         XU_SHL:   result = shl_out;
         XU_UPPER: result = shl_out;
         default:  result = '0;
      endcase
   end

endmodule

// File: rtl/exe_unit.sv
module exe_unit
   import exe_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_IDX_W = 5,
   parameter int OPC_W     = 6,
   parameter int FUN_W     = 6,
   parameter int SHAMT_W   = 5,
   parameter int IMM_W     = 16
) (
   input  logic [DATA_W-1:0]    instr,
   input  logic [DATA_W-1:0]    rs_val,
   input  logic [DATA_W-1:0]    rt_val,
   output logic [DATA_W-1:0]    alu_result,
   output logic [REG_IDX_W-1:0] dest_idx,
   output logic                 reg_we,
   output logic                 mem_rd,
   output logic                 mem_wr,
   output logic                 ovf,
   output logic                 illegal
);

   localparam int OPC_LSB = DATA_W - OPC_W;
   localparam int RS_LSB  = OPC_LSB - REG_IDX_W;
   localparam int RT_LSB  = RS_LSB - REG_IDX_W;
   localparam int RD_LSB  = RT_LSB - REG_IDX_W;
   localparam int SH_LSB  = RD_LSB - SHAMT_W;

   if (SH_LSB != FUN_W) begin : g_bad_rfmt
      $error("exe_unit: register-format fields do not fill the word");
   end
   if (RT_LSB != IMM_W) begin : g_bad_ifmt
      $error("exe_unit: immediate-format fields do not fill the word");
   end
   if ((1 << SHAMT_W) != DATA_W) begin : g_bad_shamt
      $error("exe_unit: shift-amount width must span the data width");
   end

   logic [OPC_W-1:0]     f_opc;
   logic [REG_IDX_W-1:0] f_rt, f_rd;
   logic [SHAMT_W-1:0]   f_sh;
   logic [FUN_W-1:0]     f_fun;
   logic [IMM_W-1:0]     f_imm;

   assign f_opc = instr[DATA_W-1:OPC_LSB];
   assign f_rt  = instr[RS_LSB-1:RT_LSB];
   assign f_rd  = instr[RT_LSB-1:RD_LSB];
   assign f_sh  = instr[RD_LSB-1:SH_LSB];
   assign f_fun = instr[FUN_W-1:0];
   assign f_imm = instr[IMM_W-1:0];

   xu_ctrl_t ctrl;

   exe_decode #(
      .OPC_W (OPC_W),
      .FUN_W (FUN_W)
   ) u_dec (
      .opcode (f_opc),
      .funct  (f_fun),
      .ctrl   (ctrl)
   );

   logic [DATA_W-1:0] imm_x;

   exe_immext #(
      .IMM_W  (IMM_W),
      .DATA_W (DATA_W)
   ) u_ext (
      .imm      (f_imm),
      .zero_ext (ctrl.zero_ext),
      .ext      (imm_x)
   );

   logic [DATA_W-1:0]  opb, res_raw;
   logic [SHAMT_W-1:0] shamt;
   logic               ovf_raw, ovf_hit;

   assign opb   = ctrl.use_imm ? imm_x : rt_val;
   assign shamt = ctrl.shift_by_reg ? rs_val[SHAMT_W-1:0] : f_sh;

   exe_alu #(
      .DATA_W (DATA_W),
      .SH_W   (SHAMT_W),
      .IMM_W  (IMM_W)
   ) u_alu (
      .op      (ctrl.op),
      .opa     (rs_val),
      .opb     (opb),
      .shamt   (shamt),
      .result  (res_raw),
      .ovf_raw (ovf_raw)
   );

   assign ovf_hit    = ctrl.trap_ovf & ovf_raw;
   assign alu_result = ctrl.bad ? '0 : res_raw;
   assign dest_idx   = ctrl.dst_is_rd ? f_rd : f_rt;
   assign reg_we     = ctrl.wr_reg & ~ovf_hit;
   assign mem_rd     = ctrl.rd_mem;
   assign mem_wr     = ctrl.wr_mem;
   assign ovf        = ovf_hit;
   assign illegal    = ctrl.bad;

endmodule

// File: rtl/exe_unit_chk.sv
module exe_unit_chk
   import exe_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_IDX_W = 5,
   parameter int OPC_W     = 6,
   parameter int FUN_W     = 6,
   parameter int IMM_W     = 16
) (
   input logic [DATA_W-1:0]    instr,
   input logic [DATA_W-1:0]    rs_val,
   input logic [DATA_W-1:0]    rt_val,
   input logic [DATA_W-1:0]    alu_result,
   input logic [REG_IDX_W-1:0] dest_idx,
   input logic                 reg_we,
   input logic                 mem_rd,
   input logic                 mem_wr,
   input logic                 ovf,
   input logic                 illegal
);

   localparam int OPC_LSB = DATA_W - OPC_W;
   localparam int RS_LSB  = OPC_LSB - REG_IDX_W;
   localparam int RT_LSB  = RS_LSB - REG_IDX_W;
   localparam int RD_LSB  = RT_LSB - REG_IDX_W;
   localparam int PAD_W   = DATA_W - IMM_W;

   logic [OPC_W-1:0] c_op;
   logic [FUN_W-1:0] c_fn;
   logic [DATA_W-1:0] c_sext;

   assign c_op   = instr[DATA_W-1:OPC_LSB];
   assign c_fn   = instr[FUN_W-1:0];
   assign c_sext = {{PAD_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};

   always_comb begin
      if (!$isunknown(instr) && !$isunknown(rs_val) && !$isunknown(rt_val)) begin
         AST_DEST_RFMT: assert (!(reg_we && c_op == OPC_REG) ||
                                dest_idx == instr[RT_LSB-1:RD_LSB]) else $error("dest rd"); // R1
         AST_DEST_IFMT: assert (!(reg_we && c_op != OPC_REG) ||
                                dest_idx == instr[RS_LSB-1:RT_LSB]) else $error("dest rt"); // R1
         AST_NO_OVERFLOW: assert (!(ovf && reg_we)) else $error("write on overflow"); // R3
         AST_OVF_SOURCE: assert (!ovf || c_op == OPC_ADDI ||
                                 (c_op == OPC_REG && (c_fn == FUN_ADD || c_fn == FUN_SUB)))
            else $error("overflow on non-trapping op"); // R3
         AST_UPPER_LAYOUT: assert (c_op != OPC_LUI ||
                                   alu_result == {instr[IMM_W-1:0], {PAD_W{1'b0}}})
            else $error("upper immediate layout"); // R7
         AST_LOAD_ADDR: assert (!mem_rd || (c_op == OPC_LW && reg_we &&
                                alu_result == rs_val + c_sext)) else $error("load address"); // R8
         AST_STORE_ADDR: assert (!mem_wr || (c_op == OPC_SW &&
                                 alu_result == rs_val + c_sext)) else $error("store address"); // R8
         AST_ILLEGAL_QUIET: assert (!illegal || (!reg_we && !mem_rd && !mem_wr &&
                                    alu_result == '0)) else $error("illegal not quiet"); // R9
         AST_STROBE_EXCL: assert ($onehot0({mem_rd, mem_wr}) && !(reg_we && mem_wr))
            else $error("strobe clash"); // R10
      end
   end

endmodule

bind exe_unit exe_unit_chk #(
   .DATA_W    (DATA_W),
   .REG_IDX_W (REG_IDX_W),
   .OPC_W     (OPC_W),
   .FUN_W     (FUN_W),
   .IMM_W     (IMM_W)
) u_chk (
   .instr      (instr),
   .rs_val     (rs_val),
   .rt_val     (rt_val),
   .alu_result (alu_result),
   .dest_idx   (dest_idx),
   .reg_we     (reg_we),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .ovf        (ovf),
   .illegal    (illegal)
);

// File: tb/test_exe_unit.sv
module test_exe_unit;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0, rs_val = '0, rt_val = '0;
   logic [31:0] alu_result;
   logic [4:0]  dest_idx;
   logic        reg_we, mem_rd, mem_wr, ovf, illegal;

   int n_checks = 0;
   int n_errors = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exe_unit i_exe_unit (
      .instr      (instr),
      .rs_val     (rs_val),
      .rt_val     (rt_val),
      .alu_result (alu_result),
      .dest_idx   (dest_idx),
      .reg_we     (reg_we),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .ovf        (ovf),
      .illegal    (illegal)
   );

   typedef struct {
      logic [31:0] res;
      logic [4:0]  dest;
      logic        we, mrd, mwr, ov, ill;
   } exp_t;

   function automatic logic [31:0] rw(int rs, int rt, int rd, int sh, int fn);
      return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
   endfunction

   function automatic logic [31:0] iw(int op, int rs, int rt, int imm);
      return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   // Behavioural reference: 64-bit signed arithmetic for overflow, no bit tricks.
   function automatic exp_t model(logic [31:0] w, logic [31:0] a, logic [31:0] b);
      exp_t e;
      int op = int'(w[31:26]);
      int fn = int'(w[5:0]);
      longint sa = longint'($signed(a));
      longint sb = longint'($signed(b));
      longint si = longint'($signed(w[15:0]));
      longint s;
      logic [31:0] zi = {16'h0000, w[15:0]};
      logic [31:0] sx = 32'(si);
      e = '{res: '0, dest: '0, we: 1'b1, mrd: 1'b0, mwr: 1'b0, ov: 1'b0, ill: 1'b0};
      e.dest = (op == 0) ? w[15:11] : w[20:16];
      if (op == 0) begin
         case (fn)
            32: begin s = sa + sb; e.res = 32'(s);
                e.ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            33: e.res = a + b;
            34: begin s = sa - sb; e.res = 32'(s);
                e.ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            35: e.res = a - b;
            36: e.res = a & b;
            37: e.res = a | b;
            38: e.res = a ^ b;
            39: e.res = ~(a | b);
            0:  e.res = b << w[10:6];
            4:  e.res = b << a[4:0];
            default: e.ill = 1'b1;
         endcase
      end else begin
         case (op)
            8:  begin s = sa + si; e.res = 32'(s);
                e.ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            9:  e.res = a + sx;
            12: e.res = a & zi;
            13: e.res = a | zi;
            14: e.res = a ^ zi;
            15: e.res = {w[15:0], 16'h0000};
            35: begin e.res = a + sx; e.mrd = 1'b1; end
            43: begin e.res = a + sx; e.mwr = 1'b1; e.we = 1'b0; end
            default: e.ill = 1'b1;
         endcase
      end
      if (e.ov) e.we = 1'b0;
      if (e.ill) begin
         e.res = '0; e.we = 1'b0; e.mrd = 1'b0; e.mwr = 1'b0;
      end
      return e;
   endfunction

   task automatic apply(logic [31:0] w, logic [31:0] a, logic [31:0] b, string tag);
      exp_t e;
      @(posedge clk);
      instr = w; rs_val = a; rt_val = b;
      @(negedge clk);
      e = model(w, a, b);
      n_checks++;
      if (alu_result !== e.res || reg_we !== e.we || mem_rd !== e.mrd ||
          mem_wr !== e.mwr || ovf !== e.ov || illegal !== e.ill ||
          (e.we && dest_idx !== e.dest)) begin
         n_errors++;
         $display("FAIL %s instr=%h: got res=%h dst=%0d we=%b rd=%b wr=%b ov=%b ill=%b exp res=%h dst=%0d we=%b rd=%b wr=%b ov=%b ill=%b",
                  tag, w, alu_result, dest_idx, reg_we, mem_rd, mem_wr, ovf, illegal,
                  e.res, e.dest, e.we, e.mrd, e.mwr, e.ov, e.ill);
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!done && cycles > WATCHDOG) begin
         n_errors++;
         $display("FAIL watchdog: got %0d cycles, expected under %0d", cycles, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Reset state: all-zero word is sll r0,r0,0 -> result 0, write to r0 (R1, R5)
      apply('0, '0, '0, "R1 reset word");

      apply(rw(3, 4, 9, 0, 32), 32'd100, 32'd23, "R1 R2 add dest rd");
      apply(rw(3, 4, 9, 0, 33), 32'hFFFF_FFFF, 32'd2, "R2 addu wrap");
      apply(rw(3, 4, 9, 0, 35), 32'd0, 32'd1, "R2 subu wrap");
      apply(rw(3, 4, 9, 0, 34), 32'd5, 32'd9, "R2 sub negative");
      apply(rw(1, 2, 7, 0, 32), 32'h7FFF_FFFF, 32'd1, "R3 add overflow");
      apply(rw(1, 2, 7, 0, 34), 32'h8000_0000, 32'd1, "R3 sub overflow");
      apply(rw(1, 2, 7, 0, 33), 32'h7FFF_FFFF, 32'd1, "R3 addu no flag");
      apply(rw(1, 2, 7, 0, 35), 32'h8000_0000, 32'd1, "R3 subu no flag");
      apply(iw(8, 1, 6, 1), 32'h7FFF_FFFF, '0, "R3 addi overflow");
      apply(iw(8, 1, 6, 16'h8000), 32'h8000_0000, '0, "R3 addi negative overflow");
      apply(iw(9, 1, 6, 1), 32'h7FFF_FFFF, '0, "R3 addiu no flag");
      apply(rw(5, 6, 11, 0, 36), 32'hF0F0_1234, 32'h0FF0_FF00, "R4 and");
      apply(rw(5, 6, 11, 0, 37), 32'hF0F0_1234, 32'h0FF0_FF00, "R4 or");
      apply(rw(5, 6, 11, 0, 38), 32'hF0F0_1234, 32'h0FF0_FF00, "R4 xor");
      apply(rw(5, 6, 11, 0, 39), 32'hF0F0_1234, 32'h0FF0_FF00, "R4 nor");
      apply(rw(0, 21, 18, 6, 0), '0, 32'h8000_0003, "R5 sll field");
      apply(rw(0, 21, 18, 31, 0), '0, 32'h0000_0003, "R5 sll by 31");
      apply(rw(8, 21, 18, 3, 4), 32'hFFFF_FFE4, 32'h0000_0005, "R5 sllv uses rs low bits");
      apply(iw(8, 13, 12, 25), 32'd10, '0, "R1 R6 addi dest rt");
      apply(iw(9, 13, 12, 16'hFFF6), 32'd4, '0, "R6 addiu sign extend");
      apply(iw(12, 2, 3, 16'h8F0F), 32'hFFFF_FFFF, '0, "R6 andi zero extend");
      apply(iw(13, 2, 3, 16'h8001), 32'h1234_0000, '0, "R6 ori zero extend");
      apply(iw(14, 2, 3, 16'hFFFF), 32'hAAAA_AAAA, '0, "R6 xori zero extend");
      apply(iw(15, 9, 3, 16'hBEEF), 32'hFFFF_FFFF, '0, "R7 lui");
      apply(iw(35, 4, 8, 16'hFFFC), 32'h0000_1000, '0, "R8 lw negative disp");
      apply(iw(43, 4, 8, 16'h0040), 32'h0000_1000, 32'hDEAD_BEEF, "R8 R10 sw");
      apply(iw(2, 4, 8, 16'h0040), 32'h1, 32'h2, "R9 unlisted opcode");
      apply(iw(1, 4, 1, 16'h0004), 32'h1, 32'h2, "R9 compare-zero opcode");
      apply(rw(4, 5, 6, 2, 2), 32'h40, 32'h80, "R9 unlisted function");
      apply(rw(4, 5, 6, 0, 42), 32'h40, 32'h80, "R9 unlisted function 2");

      // Mixed traffic over legal and illegal encodings (R2-R10)
      for (int k = 0; k < 400; k++) begin
         logic [31:0] w, a, b;
         int pick = int'($urandom_range(0, 19));
         int fns[10] = '{32, 33, 34, 35, 36, 37, 38, 39, 0, 4};
         int ops[8]  = '{8, 9, 12, 13, 14, 15, 35, 43};
         w = $urandom();
         a = $urandom();
         b = $urandom();
         if (k % 5 == 0) a = {a[31], {31{~a[31]}}};
         if (pick < 10) w = {6'b000000, w[25:6], 6'(fns[pick])};
         else if (pick < 18) w = {6'(ops[pick-10]), w[25:0]};
         apply(w, a, b, "R10 mixed");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule